// File: doc/BRIEF.md
# Remote DMA Data Port with Interrupt Status

This block lets a host move bytes between its data port and a local packet memory one access at a time. Software first loads a 16-bit memory address and a 16-bit transfer count, one byte per register write, and picks 8-bit or 16-bit transfers with a configuration bit. Each read or write strobe on the data port then moves one unit, advances the address and reduces the count. When the address reaches the ring's stop page it jumps back to the ring's start page, so a transfer can run across the end of a circular receive area.

The memory answers only in two windows: a small low window starting at address 0, and a high window at `HIGH_BASE`. Accesses anywhere else read as all ones and never store. With `HIGH_SIZE` at 32768 the high window covers 16384 to 49151. The default is 1024 bytes (16384 to 17407), which keeps the elaborated memory small.

The block also holds the interrupt status byte and its mask, and drives a level interrupt. Running out of count sets the completion flag (status bit 6). So does starting a remote transfer while the count is already zero. Other units raise status bits through an event input.

Top module: `rdma_port`

## Requirements
- R1: After a synchronous active-low reset, address, count, ring pages, status, mask and configuration read 0, and `irq_o` is low.
- R2: Register select codes: 0 command, 1 ring start page, 2 ring stop page, 3 address low byte, 4 address high byte, 5 count low byte, 6 count high byte, 7 status, 8 mask, 9 configuration. A byte write replaces only its byte. Reading codes 3 to 6 returns the current, advancing address and count. Code 0 and unused codes read 0.
- R3: Configuration bit 0 set selects 16-bit transfers with an address step of 2; clear selects 8-bit transfers with a step of 1. The new address and count are visible in the cycle after the strobe.
- R4: After a step, an address equal to stop page × 256 is replaced by start page × 256.
- R5: If the count is less than or equal to the step, it becomes 0 and status bit 6 is set. Otherwise the count drops by the step.
- R6: A data-port write while the count is 0 changes neither memory, address nor count. A read while the count is 0 still steps the address and sets status bit 6.
- R7: A command write with bit 0 (remote read) or bit 1 (remote write) set while the count is 0 sets status bit 6. With a non-zero count, or with neither bit set, status is unchanged.
- R8: Valid addresses are below 32 and from `HIGH_BASE` to `HIGH_BASE+HIGH_SIZE-1`. Elsewhere an 8-bit read returns 16'h00FF, a 16-bit read returns 16'hFFFF, and writes are dropped.
- R9: A 16-bit access uses the address with bit 0 cleared. The byte at the even address is data bits 7:0 and the next byte is bits 15:8. An 8-bit read returns the byte in bits 7:0 with bits 15:8 zero.
- R10: Writing the status register clears each bit 6:0 whose written bit is 1. Bit 7 cannot be cleared by a write. Event-input bits set status bits, and a set wins over a clear in the same cycle.
- R11: `irq_o` is high exactly when (status AND mask AND 8'h7F) is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` (combinational) |
| dp_wr | input | 1 | Data-port write strobe |
| dp_rd | input | 1 | Data-port read strobe (consumes the current unit) |
| dp_wdata | input | 16 | Data-port write data |
| dp_rdata | output | 16 | Data at the current address (combinational) |
| evt_i | input | 8 | Status set requests from other units |
| irq_o | output | 1 | Level interrupt |

## Verification
A wrong address or count register shows on the next data-port read as the wrong byte. It shows at the same time in the address and count readback, one cycle after the faulty step. Wrap and window mapping errors appear only when a transfer crosses the stop page or a window edge, so stimulus walks across each of these edges. A status bit that is wrongly set or cleared shows up on `irq_o` in the same cycle the mask enables it. The reference model is compared on every clock against the interrupt line, the selected register and the data-port output.

// File: rtl/rdma_pkg.sv
`timescale 1ns/1ps
// Shared constants and register select codes for the remote DMA port.
package rdma_pkg;
    localparam int AW  = 16;   // memory address width
    localparam int BW  = 8;    // register byte width
    localparam int DW  = 16;   // data port width
    localparam int RSW = 4;    // register select width

    typedef enum logic [RSW-1:0] {
        RA_CMD        = 4'd0,
        RA_RING_START = 4'd1,
        RA_RING_STOP  = 4'd2,
        RA_ADDR_LO    = 4'd3,
        RA_ADDR_HI    = 4'd4,
        RA_CNT_LO     = 4'd5,
        RA_CNT_HI     = 4'd6,
        RA_STAT       = 4'd7,
        RA_MASK       = 4'd8,
        RA_CFG        = 4'd9
    } reg_sel_e;

    localparam int CMD_RD_BIT = 0;
    localparam int CMD_WR_BIT = 1;
    localparam int DONE_BIT   = 6;
    localparam logic [BW-1:0] STAT_W1C_MASK = 8'h7F;
endpackage

// File: rtl/rdma_addr_ctl.sv
`timescale 1ns/1ps
// Address and count engine.
// Holds the current memory address and remaining count. Steps both on each
// transfer, wraps the address from the stop page to the start page, and
// flags completion. Assumes byte loads and transfers do not coincide; if they
// do, the loaded byte wins.
module rdma_addr_ctl
    import rdma_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          xfer,
    input  logic          wide,
    input  logic [BW-1:0] start_pg,
    input  logic [BW-1:0] stop_pg,
    input  logic          ld_addr_lo,
    input  logic          ld_addr_hi,
    input  logic          ld_cnt_lo,
    input  logic          ld_cnt_hi,
    input  logic [BW-1:0] ld_data,
    output logic [AW-1:0] cur_addr,
    output logic [AW-1:0] cur_cnt,
    output logic          done
);
    logic [AW-1:0] step_w;
    logic [AW-1:0] adv;
    logic [AW-1:0] nxt_addr;
    logic [AW-1:0] nxt_cnt;
    logic          last;

    // Next address with ring wrap, next count and the last-unit flag.
    always_comb begin
        step_w   = wide ? AW'(2) : AW'(1);
        adv      = cur_addr + step_w;
        nxt_addr = (adv == {stop_pg, {(AW-BW){1'b0}}}) ? {start_pg, {(AW-BW){1'b0}}} : adv;
        last     = (cur_cnt <= step_w);
        nxt_cnt  = last ? '0 : cur_cnt - step_w;
    end

    assign done = xfer & last;

    // Address and count registers: the transfer step first, byte loads override it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr <= '0;
            cur_cnt  <= '0;
        end else begin
            if (xfer) begin
                cur_addr <= nxt_addr;
                cur_cnt  <= nxt_cnt;
            end
            if (ld_addr_lo) cur_addr[BW-1:0]  <= ld_data;
            if (ld_addr_hi) cur_addr[AW-1:BW] <= ld_data;
            if (ld_cnt_lo)  cur_cnt[BW-1:0]   <= ld_data;
            if (ld_cnt_hi)  cur_cnt[AW-1:BW]  <= ld_data;
        end
    end
endmodule

// File: rtl/rdma_win_mem.sv
`timescale 1ns/1ps
// Windowed packet memory.
// Stores bytes for a low window [0, LOW_SIZE) and a high window
// [HIGH_BASE, HIGH_BASE+HIGH_SIZE), packed into one byte array. 16-bit
// accesses clear address bit 0 and are little-endian. Assumes both window
// sizes and HIGH_BASE are even, so a 16-bit pair never straddles a window edge.
module rdma_win_mem
    import rdma_pkg::*;
#(
    parameter int LOW_SIZE  = 32,
    parameter int HIGH_BASE = 16384,
    parameter int HIGH_SIZE = 1024
) (
    input  logic          clk,
    input  logic [AW-1:0] addr,
    input  logic          wide,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = LOW_SIZE + HIGH_SIZE;
    localparam int IW    = $clog2(DEPTH);
    localparam logic [AW:0] LO_END = (AW+1)'(LOW_SIZE);
    localparam logic [AW:0] HI_BEG = (AW+1)'(HIGH_BASE);
    localparam logic [AW:0] HI_END = (AW+1)'(HIGH_BASE + HIGH_SIZE);

    logic [BW-1:0] mem [DEPTH];
    logic [AW-1:0] base;
    logic          valid;
    logic [IW-1:0] idx0;
    logic [IW-1:0] idx1;

    // Effective address, window decode and packed array index.
    always_comb begin
        base  = wide ? {addr[AW-1:1], 1'b0} : addr;
        valid = ({1'b0, base} < LO_END) ||
                (({1'b0, base} >= HI_BEG) && ({1'b0, base} < HI_END));
        if ({1'b0, base} < LO_END) idx0 = IW'(base);
        else                       idx0 = IW'(base - AW'(HIGH_BASE) + AW'(LOW_SIZE));
        idx1 = {idx0[IW-1:1], 1'b1};
    end

    // Read mux: valid bytes, or all ones outside the windows.
    always_comb begin
        if (wide) rdata = valid ? {mem[idx1], mem[idx0]} : 16'hFFFF;
        else      rdata = valid ? {8'h00, mem[idx0]}     : 16'h00FF;
    end

    // Byte writes, dropped outside the windows.
    always_ff @(posedge clk) begin
        if (we && valid) begin
            mem[idx0] <= wdata[BW-1:0];
            if (wide) mem[idx1] <= wdata[DW-1:BW];
        end
    end
endmodule

// File: rtl/rdma_irq.sv
`timescale 1ns/1ps
// Interrupt status and mask.
// Status bits are set by set_bits and cleared by write-one-to-clear on
// bits 6:0; a set wins over a clear. The level interrupt is the OR of
// status AND mask over bits 6:0.
module rdma_irq
    import rdma_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stat_we,
    input  logic          mask_we,
    input  logic [BW-1:0] wdata,
    input  logic [BW-1:0] set_bits,
    output logic [BW-1:0] stat_q,
    output logic [BW-1:0] mask_q,
    output logic          irq
);
    logic [BW-1:0] clr_bits;

    // Bits a status write is allowed to clear.
    assign clr_bits = stat_we ? (wdata & STAT_W1C_MASK) : '0;

    // Status and mask registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
            mask_q <= '0;
        end else begin
            stat_q <= (stat_q & ~clr_bits) | set_bits;
            if (mask_we) mask_q <= wdata;
        end
    end

    // Level interrupt from the enabled, clearable status bits.
    assign irq = |(stat_q & mask_q & STAT_W1C_MASK);
endmodule

// File: rtl/rdma_port.sv
`timescale 1ns/1ps
// Remote DMA data port, top level.
// Decodes byte-wide register writes, steps the address/count engine on each
// data-port access, gates writes while the count is zero, and collects
// completion events into the interrupt status. Assumes the host does not
// strobe dp_rd and dp_wr together; if it does, the write wins.
module rdma_port
    import rdma_pkg::*;
#(
    parameter int LOW_SIZE  = 32,
    parameter int HIGH_BASE = 16384,
    parameter int HIGH_SIZE = 1024
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_we,
    input  logic [RSW-1:0] reg_addr,
    input  logic [BW-1:0]  reg_wdata,
    output logic [BW-1:0]  reg_rdata,
    input  logic           dp_wr,
    input  logic           dp_rd,
    input  logic [DW-1:0]  dp_wdata,
    output logic [DW-1:0]  dp_rdata,
    input  logic [BW-1:0]  evt_i,
    output logic           irq_o
);
    logic [BW-1:0] start_pg_q;
    logic [BW-1:0] stop_pg_q;
    logic [BW-1:0] cfg_q;
    logic [AW-1:0] cur_addr;
    logic [AW-1:0] cur_cnt;
    logic [BW-1:0] stat_q;
    logic [BW-1:0] mask_q;
    logic [BW-1:0] set_bits;
    logic          cnt_zero;
    logic          wr_go;
    logic          xfer;
    logic          done;
    logic          cmd_idle_start;

    // Access qualification: writes need a non-zero count, reads always step.
    always_comb begin
        cnt_zero       = (cur_cnt == '0);
        wr_go          = dp_wr && !cnt_zero;
        xfer           = wr_go || (dp_rd && !dp_wr);
        cmd_idle_start = reg_we && (reg_addr == RA_CMD) && cnt_zero &&
                         (reg_wdata[CMD_RD_BIT] || reg_wdata[CMD_WR_BIT]);
        set_bits       = evt_i;
        set_bits[DONE_BIT] = evt_i[DONE_BIT] | done | cmd_idle_start;
    end

    // Ring page and configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_pg_q <= '0;
            stop_pg_q  <= '0;
            cfg_q      <= '0;
        end else if (reg_we) begin
            if (reg_addr == RA_RING_START) start_pg_q <= reg_wdata;
            if (reg_addr == RA_RING_STOP)  stop_pg_q  <= reg_wdata;
            if (reg_addr == RA_CFG)        cfg_q      <= reg_wdata;
        end
    end

    rdma_addr_ctl u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .xfer       (xfer),
        .wide       (cfg_q[0]),
        .start_pg   (start_pg_q),
        .stop_pg    (stop_pg_q),
        .ld_addr_lo (reg_we && (reg_addr == RA_ADDR_LO)),
        .ld_addr_hi (reg_we && (reg_addr == RA_ADDR_HI)),
        .ld_cnt_lo  (reg_we && (reg_addr == RA_CNT_LO)),
        .ld_cnt_hi  (reg_we && (reg_addr == RA_CNT_HI)),
        .ld_data    (reg_wdata),
        .cur_addr   (cur_addr),
        .cur_cnt    (cur_cnt),
        .done       (done)
    );

    rdma_win_mem #(
        .LOW_SIZE  (LOW_SIZE),
        .HIGH_BASE (HIGH_BASE),
        .HIGH_SIZE (HIGH_SIZE)
    ) u_mem (
        .clk   (clk),
        .addr  (cur_addr),
        .wide  (cfg_q[0]),
        .we    (wr_go),
        .wdata (dp_wdata),
        .rdata (dp_rdata)
    );

    rdma_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .stat_we  (reg_we && (reg_addr == RA_STAT)),
        .mask_we  (reg_we && (reg_addr == RA_MASK)),
        .wdata    (reg_wdata),
        .set_bits (set_bits),
        .stat_q   (stat_q),
        .mask_q   (mask_q),
        .irq      (irq_o)
    );

    // Register read mux.
    always_comb begin
        case (reg_addr)
            RA_RING_START: reg_rdata = start_pg_q;
            RA_RING_STOP:  reg_rdata = stop_pg_q;
            RA_ADDR_LO:    reg_rdata = cur_addr[BW-1:0];
            RA_ADDR_HI:    reg_rdata = cur_addr[AW-1:BW];
            RA_CNT_LO:     reg_rdata = cur_cnt[BW-1:0];
            RA_CNT_HI:     reg_rdata = cur_cnt[AW-1:BW];
            RA_STAT:       reg_rdata = stat_q;
            RA_MASK:       reg_rdata = mask_q;
            RA_CFG:        reg_rdata = cfg_q;
            default:       reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/rdma_port_chk.sv
`timescale 1ns/1ps
// Property checker for rdma_port, attached with bind.
// Watches the port strobes together with the address, count and status state.
module rdma_port_chk
    import rdma_pkg::*;
(
    input logic           clk,
    input logic           rst_n,
    input logic           reg_we,
    input logic [RSW-1:0] reg_addr,
    input logic [BW-1:0]  reg_wdata,
    input logic           dp_wr,
    input logic           dp_rd,
    input logic           irq_o,
    input logic           wide,
    input logic [BW-1:0]  start_pg,
    input logic [BW-1:0]  stop_pg,
    input logic [AW-1:0]  cur_addr,
    input logic [AW-1:0]  cur_cnt,
    input logic [BW-1:0]  stat_q
);
    // R6: a write with zero count leaves address and count alone.
    assert_zero_write_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_wr && cur_cnt == '0 && !reg_we) |=> ($stable(cur_addr) && $stable(cur_cnt)));

    // R2: with no access and no register write, address and count hold.
    assert_idle_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!dp_wr && !dp_rd && !reg_we) |=> ($stable(cur_addr) && $stable(cur_cnt)));

    // R5: a read with a large count reduces it by exactly one step.
    assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_rd && !dp_wr && !reg_we && cur_cnt > 16'd2)
        |=> (cur_cnt == $past(cur_cnt) - ($past(wide) ? 16'd2 : 16'd1)));

    // R5: consuming the last unit raises the completion flag.
    assert_done_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_rd && !dp_wr && cur_cnt <= 16'd1) |=> stat_q[DONE_BIT]);

    // R4: a step landing on the stop page lands on the start page instead.
    assert_ring_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_rd && !dp_wr && !reg_we &&
         (cur_addr + (wide ? 16'd2 : 16'd1)) == {stop_pg, 8'h00})
        |=> (cur_addr == {$past(start_pg), 8'h00}));

    // R7: starting a remote transfer with zero count raises completion.
    assert_idle_start_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == RA_CMD && (reg_wdata & 8'h03) != 8'h00 && cur_cnt == '0)
        |=> stat_q[DONE_BIT]);

    // R10: status bit 7 cannot be cleared by software.
    assert_top_bit_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stat_q[7] |=> stat_q[7]);

    // R11: the interrupt needs a pending clearable status bit.
    assert_irq_has_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (stat_q[6:0] != 7'd0));
endmodule

bind rdma_port rdma_port_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .dp_wr     (dp_wr),
    .dp_rd     (dp_rd),
    .irq_o     (irq_o),
    .wide      (cfg_q[0]),
    .start_pg  (start_pg_q),
    .stop_pg   (stop_pg_q),
    .cur_addr  (cur_addr),
    .cur_cnt   (cur_cnt),
    .stat_q    (stat_q)
);

// File: tb/rdma_port_tb_top.sv
`timescale 1ns/1ps
// Bench: a behavioural reference model updated on every rising edge and
// compared against irq, the selected register and the data port each cycle.
module rdma_port_tb_top;
    localparam int LOW = 32;
    localparam int HB  = 16384;
    localparam int HS  = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        b_reg_we = 1'b0;
    logic [3:0]  b_reg_addr = 4'd0;
    logic [7:0]  b_reg_wdata = 8'd0;
    logic        b_dp_wr = 1'b0;
    logic        b_dp_rd = 1'b0;
    logic [15:0] b_dp_wdata = 16'd0;
    logic [7:0]  b_evt = 8'd0;
    logic [7:0]  reg_rdata;
    logic [15:0] dp_rdata;
    logic        irq_o;

    int vectors = 0;
    int miscompares = 0;
    int cyc = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    rdma_port #(.LOW_SIZE(LOW), .HIGH_BASE(HB), .HIGH_SIZE(HS)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(b_reg_we), .reg_addr(b_reg_addr),
        .reg_wdata(b_reg_wdata), .reg_rdata(reg_rdata), .dp_wr(b_dp_wr),
        .dp_rd(b_dp_rd), .dp_wdata(b_dp_wdata), .dp_rdata(dp_rdata),
        .evt_i(b_evt), .irq_o(irq_o)
    );

    // ---------------- reference model ----------------
    int m_addr, m_cnt, m_start, m_stop, m_stat, m_mask, m_cfg;
    int s_step, s_set, s_base, s_next;
    bit s_wgo, s_go;
    logic [7:0] m_mem [int];

    function automatic bit m_valid(int a);
        return (a < LOW) || (a >= HB && a < HB + HS);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_addr = 0; m_cnt = 0; m_start = 0; m_stop = 0;
            m_stat = 0; m_mask = 0; m_cfg = 0;
        end else begin
            s_step = (m_cfg & 1) != 0 ? 2 : 1;
            s_set  = int'(b_evt);
            s_wgo  = b_dp_wr && (m_cnt != 0);
            s_go   = s_wgo || (b_dp_rd && !b_dp_wr);
            if (b_reg_we && b_reg_addr == 4'd0 && (b_reg_wdata & 8'h03) != 0 && m_cnt == 0)
                s_set = s_set | 'h40;
            if (s_go) begin
                s_base = (s_step == 2) ? (m_addr & 'hFFFE) : m_addr;
                if (s_wgo && m_valid(s_base))
                    for (int k = 0; k < s_step; k++) m_mem[s_base + k] = b_dp_wdata[8*k +: 8];
                s_next = (m_addr + s_step) & 'hFFFF;
                if (s_next == m_stop * 256) s_next = m_start * 256;
                m_addr = s_next;
                if (m_cnt <= s_step) begin m_cnt = 0; s_set = s_set | 'h40; end
                else m_cnt = m_cnt - s_step;
            end
            if (b_reg_we && b_reg_addr == 4'd7) m_stat = m_stat & ~(int'(b_reg_wdata) & 'h7F);
            m_stat = m_stat | s_set;
            if (b_reg_we) begin
                case (b_reg_addr)
                    4'd1: m_start = b_reg_wdata;
                    4'd2: m_stop  = b_reg_wdata;
                    4'd3: m_addr  = (m_addr & 'hFF00) | b_reg_wdata;
                    4'd4: m_addr  = (m_addr & 'h00FF) | (int'(b_reg_wdata) << 8);
                    4'd5: m_cnt   = (m_cnt & 'hFF00) | b_reg_wdata;
                    4'd6: m_cnt   = (m_cnt & 'h00FF) | (int'(b_reg_wdata) << 8);
                    4'd8: m_mask  = b_reg_wdata;
                    4'd9: m_cfg   = b_reg_wdata;
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [7:0] m_rreg(logic [3:0] a);
        case (a)
            4'd1: return 8'(m_start);
            4'd2: return 8'(m_stop);
            4'd3: return 8'(m_addr);
            4'd4: return 8'(m_addr >> 8);
            4'd5: return 8'(m_cnt);
            4'd6: return 8'(m_cnt >> 8);
            4'd7: return 8'(m_stat);
            4'd8: return 8'(m_mask);
            4'd9: return 8'(m_cfg);
            default: return 8'h00;
        endcase
    endfunction

    // Returns 1 when the model knows the data-port value.
    function automatic bit m_dp(output logic [15:0] v);
        int b;
        v = 16'h0;
        if ((m_cfg & 1) != 0) begin
            b = m_addr & 'hFFFE;
            if (!m_valid(b)) begin v = 16'hFFFF; return 1; end
            if (m_mem.exists(b) && m_mem.exists(b + 1)) begin v = {m_mem[b + 1], m_mem[b]}; return 1; end
            return 0;
        end
        if (!m_valid(m_addr)) begin v = 16'h00FF; return 1; end
        if (m_mem.exists(m_addr)) begin v = {8'h00, m_mem[m_addr]}; return 1; end
        return 0;
    endfunction

    // ---------------- checking helpers ----------------
    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic idle();
        b_reg_we = 0; b_dp_wr = 0; b_dp_rd = 0; b_evt = 0;
        b_reg_addr = 4'(1 + (cyc % 9));
    endtask

    // One clock: compare model and design, then advance to the next falling edge.
    task automatic tick(string tag);
        logic [15:0] v;
        #0.5;
        chk("R11 irq", {15'd0, irq_o}, {15'd0, ((m_stat & m_mask & 'h7F) != 0)});
        chk("R2 register readback", {8'd0, reg_rdata}, {8'd0, m_rreg(b_reg_addr)});
        if (m_dp(v)) chk(tag, dp_rdata, v);
        @(posedge clk);
        @(negedge clk);
        cyc++;
        idle();
    endtask

    task automatic wreg(int a, int d, string tag);
        b_reg_we = 1; b_reg_addr = 4'(a); b_reg_wdata = 8'(d);
        tick(tag);
    endtask

    task automatic xreg(int a, int exp, string tag);
        b_reg_addr = 4'(a);
        #0.5;
        chk(tag, {8'd0, reg_rdata}, 16'(exp));
        tick(tag);
    endtask

    task automatic xirq(bit exp, string tag);
        #0.5;
        chk(tag, {15'd0, irq_o}, {15'd0, exp});
        tick(tag);
    endtask

    task automatic dwr(int d, string tag);
        b_dp_wr = 1; b_dp_wdata = 16'(d);
        tick(tag);
    endtask

    task automatic drd(string tag);
        b_dp_rd = 1;
        tick(tag);
    endtask

    task automatic xdrd(int exp, string tag);
        b_dp_rd = 1;
        #0.5;
        chk(tag, dp_rdata, 16'(exp));
        tick(tag);
    endtask

    task automatic setup(int a, int n, string tag);
        wreg(3, a & 'hFF, tag);
        wreg(4, (a >> 8) & 'hFF, tag);
        wreg(5, n & 'hFF, tag);
        wreg(6, (n >> 8) & 'hFF, tag);
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired actual=running expected=finished");
        report();
    end

    // ---------------- stimulus ----------------
    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        idle();

        // R1: reset state
        xreg(3, 0, "R1 addr lo"); xreg(4, 0, "R1 addr hi"); xreg(5, 0, "R1 count");
        xreg(7, 0, "R1 status"); xreg(9, 0, "R1 cfg"); xirq(0, "R1 irq");

        // R2: ring pages and byte loads
        wreg(1, 'h40, "R2"); wreg(2, 'h42, "R2");
        xreg(1, 'h40, "R2 start page"); xreg(2, 'h42, "R2 stop page"); xreg(0, 0, "R2 cmd reads 0");
        setup('h41FD, 5, "R2");
        xreg(4, 'h41, "R2 addr hi"); xreg(5, 5, "R2 count lo");

        // R3/R4: 8-bit writes across the ring stop page
        dwr('hA0, "R3"); dwr('hA1, "R3"); dwr('hA2, "R4");
        xreg(3, 'h00, "R4 wrapped addr lo"); xreg(4, 'h40, "R4 wrapped addr hi");
        dwr('hA3, "R4"); dwr('hA4, "R5");
        xreg(5, 0, "R5 count empty"); xreg(7, 'h40, "R5 done flag");

        // R6: write with zero count is ignored
        dwr('h77, "R6");
        xreg(3, 'h02, "R6 addr lo held"); xreg(4, 'h40, "R6 addr hi held"); xreg(5, 0, "R6 count held");
        wreg(7, 'h40, "R10"); xreg(7, 0, "R10 cleared");

        // R3/R4: 8-bit reads back across the wrap
        setup('h41FD, 5, "R3");
        xdrd('h00A0, "R3 byte0"); xdrd('h00A1, "R3 byte1"); xdrd('h00A2, "R3 byte2");
        xdrd('h00A3, "R4 byte after wrap"); xdrd('h00A4, "R4 byte4");
        wreg(7, 'h40, "R10");
        drd("R6");
        xreg(3, 'h03, "R6 zero-count read steps"); xreg(7, 'h40, "R6 zero-count read done");

        // R9: 16-bit little-endian, odd address aligned down
        wreg(9, 1, "R3");
        setup('h0010, 4, "R9");
        dwr('hBEEF, "R9"); dwr('h1234, "R9");
        xreg(3, 'h14, "R3 step of two"); xreg(5, 0, "R5 count 4 by 2");
        setup('h0011, 3, "R9");
        xdrd('hBEEF, "R9 odd address aligned");
        xreg(3, 'h13, "R3 addr after 16-bit"); xreg(5, 1, "R5 count 3 to 1");
        wreg(7, 'h40, "R10");
        xdrd('h1234, "R9 second word");
        xreg(5, 0, "R5 count 1 with step 2"); xreg(7, 'h40, "R5 done at count 1");
        wreg(9, 0, "R9");
        setup('h0010, 2, "R9");
        xdrd('h00EF, "R9 low byte even"); xdrd('h00BE, "R9 high byte odd");

        // R8: window edges and discarded writes
        wreg(9, 1, "R8");
        setup('h0100, 4, "R8");
        xdrd('hFFFF, "R8 gap 16-bit");
        setup('h0102, 2, "R8");
        dwr('h5555, "R8");
        setup('h0102, 2, "R8");
        xdrd('hFFFF, "R8 write discarded");
        wreg(9, 0, "R8");
        setup('h4400, 2, "R8");
        xdrd('h00FF, "R8 above high window");
        setup('h0020, 1, "R8");
        xdrd('h00FF, "R8 above low window");
        setup('h43FF, 1, "R8");
        dwr('h3C, "R8");
        setup('h43FF, 1, "R8");
        xdrd('h003C, "R8 last high byte");

        // R4: 16-bit wrap
        wreg(9, 1, "R4");
        setup('h41FE, 2, "R4");
        dwr('hCAFE, "R4");
        xreg(3, 0, "R4 16-bit wrap lo"); xreg(4, 'h40, "R4 16-bit wrap hi");

        // R7: command with zero count
        wreg(7, 'h7F, "R10"); xreg(7, 0, "R10 all cleared");
        wreg(0, 'h01, "R7");
        xreg(7, 'h40, "R7 read start with zero count");
        wreg(7, 'h40, "R10");
        setup('h0000, 3, "R7");
        wreg(0, 'h02, "R7");
        xreg(7, 0, "R7 nonzero count no done");
        wreg(5, 0, "R7");
        wreg(0, 'h04, "R7");
        xreg(7, 0, "R7 other command bit no done");

        // R10/R11: sticky bit 7, set over clear, masking
        b_evt = 8'h80; tick("R10");
        xreg(7, 'h80, "R10 event sets bit7");
        wreg(7, 'hFF, "R10");
        xreg(7, 'h80, "R10 bit7 not cleared");
        wreg(8, 'hFF, "R11");
        xirq(0, "R11 bit7 never interrupts");
        b_evt = 8'h01; tick("R11");
        xirq(1, "R11 enabled bit interrupts");
        b_evt = 8'h02; b_reg_we = 1; b_reg_addr = 4'd7; b_reg_wdata = 8'h03; tick("R10");
        xreg(7, 'h82, "R10 set wins over clear");
        wreg(8, 'h80, "R11");
        xirq(0, "R11 masked off");
        wreg(8, 'h02, "R11");
        xirq(1, "R11 mask enables");

        repeat (4) tick("R2");
        report();
    end
endmodule